// File: doc/BRIEF.md
# Lockable Legacy SMM Window Decoder

This block decides where memory requests aimed at the legacy system-management window at 0xA0000 through 0xBFFFF should go. Each request carries an address, a flag for system-management mode and a flag that marks it as a code fetch or a data reference. The block sends each window request either to local DRAM or on to the legacy video/IO path. The address is not remapped on either route. Requests outside the window are passed through and marked as neither route.

A byte-wide configuration port reaches two registers. The window control register holds open, close and lock bits. The companion register holds the global SMRAM enable, a high-SMRAM enable, a TSEG enable and a TSEG size field. Once lock is set, it clears open and freezes the lockable fields. Only the full reset releases the lock. The warm reset does not.

Requests enter on a valid/ready interface and leave on a registered valid/ready interface. The rules for back-pressure are:
- A request is accepted on a clock edge where both `req_valid` and `req_ready` are high.
- `req_ready` is high whenever the output stage is empty or is being drained in the same cycle.
- A pending result stays unchanged until `rsp_ready` takes it.

Top module: `smram_window_ctl`

## Requirements
- R1: After full reset the control register reads 0x02 (select 0), the companion register reads 0x00 (select 1), `proto_viol` is 0 and `rsp_valid` is 0.
- R2: Control register layout: bit 6 is open, bit 5 is close, bit 4 is lock, and bits 2:0 always read 3'b010. Bits 7 and 3 always read 0, and writes to bits 7, 3 and 2:0 have no effect.
- R3: Companion register layout: bit 0 is the global enable, bit 1 is the high enable, bit 2 is the TSEG enable and bits 5:3 are the TSEG size; bits 7:6 read 0. While the global enable is 0, every window request is routed to the legacy path, whatever open, close and SMM mode are.
- R4: With the global enable set and open, close and lock at 0, a window request in SMM mode goes to DRAM and a window request outside SMM mode goes to the legacy path.
- R5: With open=1 and lock=0, a window request outside SMM mode goes to DRAM.
- R6: With close=1, a data reference to the window goes to the legacy path even in SMM mode, while a code fetch in SMM mode still goes to DRAM.
- R7: `proto_viol` is 1 exactly while open and close are both 1. In that state, a non-SMM data reference goes to the legacy path and a non-SMM code fetch goes to DRAM.
- R8: A control write with bit 4 set stores open as 0 even if bit 6 is also set. After it, non-SMM window requests go to the legacy path.
- R9: While locked, control writes leave open and lock unchanged and companion writes are ignored. Close stays writable.
- R10: Lock, once set, is cleared only by `rst_full_n`. The warm reset `rst_warm_n` clears open and close, leaves lock and the companion register unchanged, and empties the output stage.
- R11: A request below 0xA0000 or above 0xBFFFF comes out with `rsp_dram`=0 and `rsp_legacy`=0. On every route, `rsp_addr` equals the request address.
- R12: A result appears one cycle after acceptance. While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and the result holds stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_full_n | input | 1 | Full reset, asynchronous, active low; clears everything including lock |
| rst_warm_n | input | 1 | Warm reset, synchronous, active low; clears open, close and output stage |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 companion |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Read byte of the selected register |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | ADDR_W | Request address |
| req_smm | input | 1 | Request issued in system-management mode |
| req_code | input | 1 | 1 for a code fetch, 0 for a data reference |
| rsp_valid | output | 1 | Routed result valid |
| rsp_ready | input | 1 | Downstream takes the result |
| rsp_addr | output | ADDR_W | Address of the routed request, unchanged |
| rsp_dram | output | 1 | Window request goes to local DRAM |
| rsp_legacy | output | 1 | Window request forwarded to legacy video/IO |
| proto_viol | output | 1 | Open and close are set together |

## Verification
The routing is driven with every combination of SMM mode and code versus data under each control setting: all clear, open only, close only, open with close, and locked. This shows that open acts only outside SMM mode, and that close acts only on data. It also shows that close wins when both are set. The window is probed at both edges and one byte beyond each edge, which catches errors in the bounds. The same routing patterns are repeated with the global enable off, and after a locked write that tries to reopen, so that a gate that leaks is visible at the route outputs. A stalled-output pattern checks that nothing is lost and nothing changes under back-pressure.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int WIN_AW = 20;
  localparam logic [WIN_AW-1:0] WIN_LO = 20'hA0000;
  localparam logic [WIN_AW-1:0] WIN_HI = 20'hBFFFF;
  localparam logic [2:0] BASE_SEG = 3'b010;

  localparam int CB_OPEN  = 6;
  localparam int CB_CLOSE = 5;
  localparam int CB_LOCK  = 4;

  localparam int PB_GEN   = 0;
  localparam int PB_HIGH  = 1;
  localparam int PB_TSEG  = 2;
  localparam int PB_SZ_LO = 3;
  localparam int SZ_W     = 3;

  typedef struct packed {
    logic open;
    logic close;
    logic lock;
  } win_ctl_t;

  typedef struct packed {
    logic [SZ_W-1:0] tseg_sz;
    logic            tseg_en;
    logic            high_en;
    logic            gen;
  } win_comp_t;

  typedef enum logic [1:0] {
    ROUTE_NONE   = 2'b00,
    ROUTE_LEGACY = 2'b01,
    ROUTE_DRAM   = 2'b10
  } route_e;
endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_full_n,
  input  logic       rst_warm_n,
  input  logic       cfg_wr,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output win_ctl_t   ctl,
  output logic       gen
);
  win_comp_t comp;
  logic      unused_wbits;

  assign unused_wbits = cfg_wdata[7];
  assign gen = comp.gen;

  always_ff @(posedge clk or negedge rst_full_n) begin
    if (!rst_full_n) begin
      ctl  <= '0;
      comp <= '0;
    end else if (!rst_warm_n) begin
      ctl.open  <= 1'b0;
      ctl.close <= 1'b0;
    end else if (cfg_wr) begin
      if (!cfg_sel) begin
        ctl.close <= cfg_wdata[CB_CLOSE];
        if (!ctl.lock) begin
          ctl.lock <= cfg_wdata[CB_LOCK];
          ctl.open <= cfg_wdata[CB_OPEN] & ~cfg_wdata[CB_LOCK];
        end
      end else if (!ctl.lock) begin
        comp.gen     <= cfg_wdata[PB_GEN];
        comp.high_en <= cfg_wdata[PB_HIGH];
        comp.tseg_en <= cfg_wdata[PB_TSEG];
        comp.tseg_sz <= cfg_wdata[PB_SZ_LO +: SZ_W];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (!cfg_sel) begin
      cfg_rdata[CB_OPEN]  = ctl.open;
      cfg_rdata[CB_CLOSE] = ctl.close;
      cfg_rdata[CB_LOCK]  = ctl.lock;
      cfg_rdata[2:0]      = BASE_SEG;
    end else begin
      cfg_rdata[PB_GEN]              = comp.gen;
      cfg_rdata[PB_HIGH]             = comp.high_en;
      cfg_rdata[PB_TSEG]             = comp.tseg_en;
      cfg_rdata[PB_SZ_LO +: SZ_W]    = comp.tseg_sz;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_full_n)
    ctl.lock |=> ctl.lock); // R10
  AST_LOCK_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_full_n)
    ctl.lock |-> !ctl.open); // R8
  AST_COMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_full_n)
    ctl.lock |=> $stable(comp)); // R9
endmodule

// File: rtl/smram_win_decode.sv
module smram_win_decode
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  input  logic              code,
  input  win_ctl_t          ctl,
  input  logic              gen,
  output route_e            route
);
  logic in_win;
  logic visible;

  generate
    if (ADDR_W > WIN_AW) begin : g_wide
      logic upper_zero;
      assign upper_zero = (addr[ADDR_W-1:WIN_AW] == '0);
      assign in_win = upper_zero && (addr[WIN_AW-1:0] >= WIN_LO)
                      && (addr[WIN_AW-1:0] <= WIN_HI);
    end else begin : g_exact
      assign in_win = (addr >= WIN_LO) && (addr <= WIN_HI);
    end
  endgenerate

  // close blocks data on both paths; open grants non-SMM access unless locked
  assign visible = gen && !(ctl.close && !code)
                   && (smm || (ctl.open && !ctl.lock));

  always_comb begin
    if (!in_win)      route = ROUTE_NONE;
    else if (visible) route = ROUTE_DRAM;
    else              route = ROUTE_LEGACY;
  end
endmodule

// File: rtl/smram_rsp_slice.sv
module smram_rsp_slice
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_full_n,
  input  logic              rst_warm_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  route_e            in_route,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output route_e            out_route
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_full_n) begin
    if (!rst_full_n)      out_valid <= 1'b0;
    else if (!rst_warm_n) out_valid <= 1'b0;
    else if (in_ready)    out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_full_n) begin
    if (!rst_full_n) begin
      out_addr  <= '0;
      out_route <= ROUTE_NONE;
    end else if (in_valid && in_ready) begin
      out_addr  <= in_addr;
      out_route <= in_route;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk)
    disable iff (!rst_full_n || !rst_warm_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                   && $stable(out_route))); // R12
  AST_ACCEPT_SHOWS: assert property (@(posedge clk)
    disable iff (!rst_full_n || !rst_warm_n)
    (in_valid && in_ready) |=> out_valid); // R12
endmodule

// File: rtl/smram_window_ctl.sv
module smram_window_ctl
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_full_n,
  input  logic              rst_warm_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_smm,
  input  logic              req_code,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_dram,
  output logic              rsp_legacy,
  output logic              proto_viol
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(WIN_HI);

  win_ctl_t ctl;
  logic     gen;
  route_e   dec_route;
  route_e   out_route;

  smram_cfg_regs u_regs (
    .clk       (clk),
    .rst_full_n(rst_full_n),
    .rst_warm_n(rst_warm_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .ctl       (ctl),
    .gen       (gen)
  );

  smram_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .smm  (req_smm),
    .code (req_code),
    .ctl  (ctl),
    .gen  (gen),
    .route(dec_route)
  );

  smram_rsp_slice #(.ADDR_W(ADDR_W)) u_slice (
    .clk       (clk),
    .rst_full_n(rst_full_n),
    .rst_warm_n(rst_warm_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_addr   (req_addr),
    .in_route  (dec_route),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_addr  (rsp_addr),
    .out_route (out_route)
  );

  assign rsp_dram   = (out_route == ROUTE_DRAM);
  assign rsp_legacy = (out_route == ROUTE_LEGACY);
  assign proto_viol = ctl.open && ctl.close;

  AST_OUTSIDE_NONE: assert property (@(posedge clk) disable iff (!rst_full_n)
    (rsp_valid && ((rsp_addr < LO_A) || (rsp_addr > HI_A)))
      |-> (!rsp_dram && !rsp_legacy)); // R11
  AST_GEN_OFF_NODRAM: assert property (@(posedge clk)
    disable iff (!rst_full_n || !rst_warm_n)
    (req_valid && req_ready && !gen) |=> !rsp_dram); // R3
  AST_INSIDE_ROUTED: assert property (@(posedge clk) disable iff (!rst_full_n)
    (rsp_valid && (rsp_addr >= LO_A) && (rsp_addr <= HI_A))
      |-> (rsp_dram || rsp_legacy)); // R11
endmodule

// File: tb/sim_smram_window_ctl.sv
module sim_smram_window_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_full_n = 1'b0;
  logic          rst_warm_n = 1'b1;
  logic          cfg_wr = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_smm = 1'b0;
  logic          req_code = 1'b0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [AW-1:0] rsp_addr;
  logic          rsp_dram;
  logic          rsp_legacy;
  logic          proto_viol;

  int total = 0;
  int bad = 0;

  logic m_open = 0, m_close = 0, m_lock = 0;
  logic [7:0] m_comp = '0;

  logic [1:0]    q_route[$];
  logic [AW-1:0] q_addr[$];
  string         q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  smram_window_ctl #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_full_n(rst_full_n), .rst_warm_n(rst_warm_n),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_smm(req_smm), .req_code(req_code),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_dram(rsp_dram), .rsp_legacy(rsp_legacy), .proto_viol(proto_viol)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // expected route {dram, legacy} from the requirements
  function automatic logic [1:0] model_route(input logic [AW-1:0] a,
                                             input logic smm, input logic code);
    logic vis;
    if (a < 32'hA0000 || a > 32'hBFFFF) return 2'b00;
    vis = m_comp[0] && !(m_close && !code) && (smm || (m_open && !m_lock));
    return vis ? 2'b10 : 2'b01;
  endfunction

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (!sel) begin
      m_close = d[5];
      if (!m_lock) begin
        m_lock = d[4];
        m_open = d[6] & ~d[4];
      end
    end else if (!m_lock) begin
      m_comp = d & 8'h3F;
    end
  endtask

  task automatic cfg_check(input string tag, input logic sel,
                           input logic [7:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    check(tag, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic send(input string tag, input logic [AW-1:0] a,
                      input logic smm, input logic code);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_smm = smm; req_code = code;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    q_route.push_back(model_route(a, smm, code));
    q_addr.push_back(a);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: scoreboard pop on each handshake
  always begin
    @(negedge clk);
    #2;
    if (rst_full_n && rst_warm_n && rsp_valid && rsp_ready) begin
      if (q_route.size() == 0) begin
        total++; bad++;
        $display("FAIL R12 unexpected result actual=0x%0h expected=none", rsp_addr);
      end else begin
        string t;
        logic [1:0] er;
        logic [AW-1:0] ea;
        t = q_tag.pop_front();
        er = q_route.pop_front();
        ea = q_addr.pop_front();
        check(t, {30'h0, rsp_dram, rsp_legacy}, {30'h0, er});
        check("R11 addr", rsp_addr, ea);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] held;
    repeat (3) @(negedge clk);
    rst_full_n = 1'b1;
    cfg_check("R1 ctl reset", 1'b0, 8'h02);
    cfg_check("R1 comp reset", 1'b1, 8'h00);
    check("R1 proto", {31'h0, proto_viol}, 32'h0);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);

    // R3: global enable off
    send("R3 smm data", 32'hA0000, 1'b1, 1'b0);
    send("R3 smm code", 32'hB8000, 1'b1, 1'b1);
    cfg_write(1'b1, 8'hFF);
    cfg_check("R3 comp layout", 1'b1, 8'h3F);
    cfg_write(1'b1, 8'h00);
    cfg_write(1'b0, 8'h40);
    send("R3 open gen off", 32'hA8000, 1'b0, 1'b0);
    cfg_write(1'b0, 8'h00);

    // R2 layout
    cfg_write(1'b0, 8'h8F);
    cfg_check("R2 reserved/base", 1'b0, 8'h02);

    // R4 base routing and R11 edges
    cfg_write(1'b1, 8'h01);
    send("R4 smm data lo", 32'hA0000, 1'b1, 1'b0);
    send("R4 nonsmm data hi", 32'hBFFFF, 1'b0, 1'b0);
    send("R4 nonsmm code", 32'hB0000, 1'b0, 1'b1);
    send("R11 above", 32'hC0000, 1'b1, 1'b0);
    send("R11 below", 32'h9FFFF, 1'b1, 1'b0);
    send("R11 high bits", 32'h100A0000, 1'b1, 1'b0);

    // R5 open
    cfg_write(1'b0, 8'h40);
    cfg_check("R5 readback", 1'b0, 8'h42);
    send("R5 nonsmm data", 32'hA1234, 1'b0, 1'b0);
    send("R5 nonsmm code", 32'hBFFFF, 1'b0, 1'b1);

    // R7 open and close together
    cfg_write(1'b0, 8'h60);
    check("R7 proto set", {31'h0, proto_viol}, 32'h1);
    send("R7 nonsmm data", 32'hA5000, 1'b0, 1'b0);
    send("R7 nonsmm code", 32'hA5000, 1'b0, 1'b1);

    // R6 close only
    cfg_write(1'b0, 8'h20);
    check("R7 proto clear", {31'h0, proto_viol}, 32'h0);
    send("R6 smm data", 32'hA0000, 1'b1, 1'b0);
    send("R6 smm code", 32'hA0000, 1'b1, 1'b1);
    send("R6 nonsmm code", 32'hA0000, 1'b0, 1'b1);
    cfg_write(1'b0, 8'h00);

    // R12 back-pressure
    @(negedge clk);
    #1 rsp_ready = 1'b0;
    send("R12 stalled", 32'hB1000, 1'b1, 1'b0);
    #1;
    check("R12 valid", {31'h0, rsp_valid}, 32'h1);
    check("R12 ready low", {31'h0, req_ready}, 32'h0);
    held = rsp_addr;
    @(negedge clk);
    #1;
    check("R12 held", rsp_addr, held);
    check("R12 still valid", {31'h0, rsp_valid}, 32'h1);
    rsp_ready = 1'b1;
    @(negedge clk);

    // R8 lock with open
    cfg_write(1'b1, 8'h3F);
    cfg_write(1'b0, 8'h50);
    cfg_check("R8 open dropped", 1'b0, 8'h12);
    send("R8 nonsmm data", 32'hA0000, 1'b0, 1'b0);
    send("R8 smm data", 32'hA0000, 1'b1, 1'b0);

    // R9 frozen fields
    cfg_write(1'b0, 8'h40);
    cfg_check("R9 open ignored", 1'b0, 8'h12);
    send("R9 nonsmm after reopen", 32'hB0000, 1'b0, 1'b1);
    cfg_write(1'b1, 8'h00);
    cfg_check("R9 comp frozen", 1'b1, 8'h3F);
    cfg_write(1'b0, 8'h20);
    cfg_check("R9 close writable", 1'b0, 8'h32);

    // R10 warm reset keeps lock
    @(negedge clk);
    rst_warm_n = 1'b0;
    @(negedge clk);
    rst_warm_n = 1'b1;
    m_open = 0; m_close = 0;
    cfg_check("R10 warm lock kept", 1'b0, 8'h12);
    cfg_check("R10 warm comp kept", 1'b1, 8'h3F);

    // R10 full reset clears lock
    @(negedge clk);
    rst_full_n = 1'b0;
    @(negedge clk);
    rst_full_n = 1'b1;
    m_open = 0; m_close = 0; m_lock = 0; m_comp = '0;
    cfg_check("R10 full ctl", 1'b0, 8'h02);
    cfg_check("R10 full comp", 1'b1, 8'h00);
    cfg_write(1'b0, 8'h40);
    cfg_check("R10 open writable again", 1'b0, 8'h42);

    repeat (4) @(negedge clk);
    check("R12 scoreboard drained", q_route.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule